// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Flags

This block is a purely combinational integer arithmetic logic unit for a datapath of parameterised width, 32 bits by default. It is assembled from one repeated single-bit slice. Each slice can optionally invert either operand, holds a full adder, and picks one of four local results. The slices are chained through a ripple carry. A 4-bit operation code selects bitwise AND, OR or NOR, addition, subtraction, or signed set-on-less-than. Alongside the result the block reports a zero flag, a carry-out flag and a signed overflow flag.

The operation code is split into fields that the slices read directly. Bit 3 inverts operand A. Bit 2 inverts operand B and also supplies the carry into slice 0. Bits 1:0 choose the slice output: 00 is AND, 01 is OR, 10 is the adder sum and 11 is the less-than input.

With this split, subtraction is A plus the inverse of B plus one. NOR is the AND of both inverted operands. Set-on-less-than runs a subtraction and takes its answer from the sign of the difference, corrected by the overflow term. The block only reports overflow. Whatever logic surrounds it decides what to do about it.

Top module: `bit_slice_alu`

## Requirements
- R1: Operation code 4'b0000 gives result = A & B, bit by bit.
- R2: Operation code 4'b0001 gives result = A | B, bit by bit.
- R3: Operation code 4'b1100 gives result = ~(A | B), bit by bit.
- R4: Operation code 4'b0010 gives result = (A + B) modulo 2^WIDTH.
- R5: Operation code 4'b0110 gives result = (A - B) modulo 2^WIDTH, formed as A + ~B + 1.
- R6: Operation code 4'b0111 gives result 1 when A is less than B as signed two's complement values, and 0 otherwise. Bits WIDTH-1..1 of this result are always 0. The answer stays correct when the internal difference overflows.
- R7: The carry flag is the carry leaving the top slice for add and subtract. For subtract it is 1 exactly when A >= B as unsigned values. It is 0 for AND, OR, NOR and set-on-less-than.
- R8: For add and subtract, the overflow flag is 1 exactly when the signed result is out of range. This is the carry into the top slice XOR the carry out of it. The flag is 0 for AND, OR, NOR and set-on-less-than.
- R9: Adding two operands of opposite sign, or subtracting two operands of the same sign, never raises the overflow flag.
- R10: The zero flag is 1 exactly when every result bit is 0, for every operation code listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code: bit 3 inverts A, bit 2 inverts B and sets carry-in, bits 1:0 select the slice output |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | All result bits are 0 |
| carry_o | output | 1 | Carry out of the top slice (add and subtract only) |
| overflow_o | output | 1 | Signed overflow (add and subtract only) |

## Verification
Every output is combinational, so the result and all three flags are due within the same cycle in which the operands and operation code change. No register sits on any path. The bench applies each stimulus just after a falling clock edge and samples all four outputs a quarter period later, well before the next rising edge. Directed vectors cover the overflow boundaries at the most positive and most negative values, comparisons whose difference overflows, and results that are exactly zero. A fixed-seed random sweep covers the six operation codes.

// File: rtl/alu_pkg.sv
// Package: shared operation codes and control-field layout for the bit-sliced ALU.
// Assumes the 4-bit code is consumed directly as {invert A, invert B, select[1:0]}.
package alu_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_AND = 4'b0000;
    localparam logic [OP_W-1:0] OP_OR  = 4'b0001;
    localparam logic [OP_W-1:0] OP_ADD = 4'b0010;
    localparam logic [OP_W-1:0] OP_SUB = 4'b0110;
    localparam logic [OP_W-1:0] OP_SLT = 4'b0111;
    localparam logic [OP_W-1:0] OP_NOR = 4'b1100;

    // Slice output selector (operation code bits 1:0).
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } sel_e;

    // Control fields as they sit in the operation code.
    typedef struct packed {
        logic inv_a;
        logic inv_b;
        sel_e sel;
    } ctl_t;

    // Split an operation code into its control fields.
    function automatic ctl_t decode_op(input logic [OP_W-1:0] op);
        ctl_t c;
        c.inv_a = op[3];
        c.inv_b = op[2];
        c.sel   = sel_e'(op[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
// Module: one-bit ALU slice.
// Conditionally inverts each operand bit, forms AND, OR and a full-adder sum,
// and selects one of these or the externally supplied less-than bit.
// Assumes the caller chains carry_o of this slice to carry_i of the next.
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic inv_a_i,
    input  logic inv_b_i,
    input  logic carry_i,
    input  logic less_i,
    input  sel_e sel_i,
    output logic res_o,
    output logic sum_o,
    output logic carry_o
);

    logic a_eff;
    logic b_eff;
    logic half;

    // Operand conditioning and full adder.
    always_comb begin
        a_eff   = a_i ^ inv_a_i;
        b_eff   = b_i ^ inv_b_i;
        half    = a_eff ^ b_eff;
        sum_o   = half ^ carry_i;
        carry_o = (a_eff & b_eff) | (carry_i & half);
    end

    // Output selection for this bit.
    always_comb begin
        unique case (sel_i)
            SEL_AND:  res_o = a_eff & b_eff;
            SEL_OR:   res_o = a_eff | b_eff;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_slice_chain.sv
// Module: ripple chain of WIDTH one-bit slices.
// Slice 0 takes its carry from the invert-B control and the less-than bit from
// set_less_i; every upper slice sees a less-than input of 0.
// Exposes only the carries around the top slice and its sum for flag logic.
module alu_slice_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  ctl_t             ctl_i,
    input  logic             set_less_i,
    output logic [WIDTH-1:0] res_o,
    output logic             sum_msb_o,
    output logic             carry_msb_in_o,
    output logic             carry_out_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum;

    // Carry into the least significant slice: 1 for subtraction forms.
    always_comb carry[0] = ctl_i.inv_b;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_bit;
        if (i == 0) begin : g_lsb
            assign less_bit = set_less_i;
        end else begin : g_upper
            assign less_bit = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctl_i.inv_a),
            .inv_b_i (ctl_i.inv_b),
            .carry_i (carry[i]),
            .less_i  (less_bit),
            .sel_i   (ctl_i.sel),
            .res_o   (res_o[i]),
            .sum_o   (sum[i]),
            .carry_o (carry[i+1])
        );
    end

    // Top-slice signals needed by the flag unit.
    always_comb begin
        sum_msb_o      = sum[MSB];
        carry_msb_in_o = carry[MSB];
        carry_out_o    = carry[WIDTH];
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Module: flag and comparison logic for the bit-sliced ALU.
// Derives raw overflow from the carries around the top slice, the signed
// less-than bit, and the reported zero, carry and overflow flags.
// Assumes carry and overflow are meaningful only when the sum is selected.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  sel_e             sel_i,
    input  logic             sum_msb_i,
    input  logic             carry_msb_in_i,
    input  logic             carry_out_i,
    input  logic [WIDTH-1:0] result_i,
    output logic             set_less_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             overflow_o
);

    logic ovf_raw;

    // Signed comparison, corrected by overflow of the difference.
    always_comb begin
        ovf_raw    = carry_msb_in_i ^ carry_out_i;
        set_less_o = sum_msb_i ^ ovf_raw;
    end

    // Reported flags.
    always_comb begin
        zero_o     = (result_i == '0);
        carry_o    = (sel_i == SEL_SUM) ? carry_out_i : 1'b0;
        overflow_o = (sel_i == SEL_SUM) ? ovf_raw : 1'b0;
    end

endmodule

// File: rtl/bit_slice_alu.sv
// Module: top of the bit-sliced integer ALU.
// Combinational: decodes the operation code, runs the slice chain and the
// flag unit. Holds no state, so it needs neither clock nor reset.
module bit_slice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             overflow_o
);

    ctl_t ctl;
    logic set_less;
    logic sum_msb;
    logic carry_msb_in;
    logic carry_out;

    // Control field split.
    always_comb ctl = decode_op(op_i);

    alu_slice_chain #(.WIDTH(WIDTH)) u_chain (
        .a_i            (a_i),
        .b_i            (b_i),
        .ctl_i          (ctl),
        .set_less_i     (set_less),
        .res_o          (result_o),
        .sum_msb_o      (sum_msb),
        .carry_msb_in_o (carry_msb_in),
        .carry_out_o    (carry_out)
    );

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .sel_i          (ctl.sel),
        .sum_msb_i      (sum_msb),
        .carry_msb_in_i (carry_msb_in),
        .carry_out_i    (carry_out),
        .result_i       (result_o),
        .set_less_o     (set_less),
        .zero_o         (zero_o),
        .carry_o        (carry_o),
        .overflow_o     (overflow_o)
    );

endmodule

// File: rtl/bit_slice_alu_chk.sv
// Module: port-level checker for bit_slice_alu, attached by bind.
// Compares outputs with word-level arithmetic. The design has no clock,
// so all checks are immediate.
module bit_slice_alu_chk
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             carry_o,
    input logic             overflow_o
);

    localparam int MSB = WIDTH - 1;

    // Per-operation output checks.
    always_comb begin
        if (op_i == OP_ADD) begin
            // R4
            add_sum_chk: assert (result_o == a_i + b_i);
        end
        if (op_i == OP_SUB) begin
            // R5
            sub_diff_chk: assert (result_o == a_i - b_i);
        end
        if (op_i == OP_NOR) begin
            // R3
            nor_value_chk: assert (result_o == ~(a_i | b_i));
        end
        if (op_i == OP_SLT) begin
            // R6
            slt_upper_chk: assert (result_o[MSB:1] == '0);
            // R10
            slt_zero_chk: assert (zero_o == !($signed(a_i) < $signed(b_i)));
        end
        if ((op_i == OP_ADD && a_i[MSB] != b_i[MSB]) ||
            (op_i == OP_SUB && a_i[MSB] == b_i[MSB])) begin
            // R9
            no_overflow_chk: assert (!overflow_o);
        end
        if (op_i == OP_AND || op_i == OP_OR || op_i == OP_NOR || op_i == OP_SLT) begin
            // R7
            logic_carry_chk: assert (!carry_o);
            // R8
            logic_overflow_chk: assert (!overflow_o);
        end
    end

endmodule

bind bit_slice_alu bit_slice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bit_slice_alu_test.sv
// Bench: directed corner cases plus fixed-seed random vectors for bit_slice_alu,
// checked against word-level reference functions.
module bit_slice_alu_test;
    import alu_pkg::*;

    localparam int W = 32;
    localparam int NRAND = 400;

    logic         clk = 1'b0;
    logic [W-1:0] a, b;
    logic [3:0]   op;
    logic [W-1:0] result;
    logic         zero, carry, overflow;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bit_slice_alu #(.WIDTH(W)) uut (
        .a_i(a), .b_i(b), .op_i(op),
        .result_o(result), .zero_o(zero), .carry_o(carry), .overflow_o(overflow)
    );

    // Reference result per requirement.
    function automatic logic [W-1:0] ref_result(input logic [W-1:0] x, y, input logic [3:0] o);
        case (o)
            OP_AND:  return x & y;                                  // R1
            OP_OR:   return x | y;                                  // R2
            OP_NOR:  return ~(x | y);                               // R3
            OP_ADD:  return x + y;                                  // R4
            OP_SUB:  return x - y;                                  // R5
            OP_SLT:  return ($signed(x) < $signed(y)) ? 1 : 0;      // R6
            default: return '0;
        endcase
    endfunction

    // Reference carry flag (R7).
    function automatic logic ref_carry(input logic [W-1:0] x, y, input logic [3:0] o);
        logic [W:0] s;
        if (o == OP_ADD) begin
            s = {1'b0, x} + {1'b0, y};
            return s[W];
        end
        if (o == OP_SUB) return (x >= y);
        return 1'b0;
    endfunction

    // Reference overflow flag from operand and result signs (R8).
    function automatic logic ref_ovf(input logic [W-1:0] x, y, input logic [3:0] o);
        logic [W-1:0] r;
        r = ref_result(x, y, o);
        if (o == OP_ADD) return (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
        if (o == OP_SUB) return (x[W-1] != y[W-1]) && (r[W-1] != x[W-1]);
        return 1'b0;
    endfunction

    // Count one check and report a mismatch.
    task automatic check(input string tag, input logic [W-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h op=%b actual=%h expected=%h", tag, a, b, op, act, exp);
        end
    endtask

    function automatic string op_tag(input logic [3:0] o);
        case (o)
            OP_AND:  return "R1 and";
            OP_OR:   return "R2 or";
            OP_NOR:  return "R3 nor";
            OP_ADD:  return "R4 add";
            OP_SUB:  return "R5 sub";
            default: return "R6 slt";
        endcase
    endfunction

    // Drive after a falling edge, sample a quarter period later.
    task automatic apply(input logic [W-1:0] x, y, input logic [3:0] o);
        logic [W-1:0] er;
        @(negedge clk);
        a = x; b = y; op = o;
        #5;
        er = ref_result(x, y, o);
        check(op_tag(o), result, er);
        check("R10 zero", {31'b0, zero}, {31'b0, er == '0});
        check("R7 carry", {31'b0, carry}, {31'b0, ref_carry(x, y, o)});
        check("R8 overflow", {31'b0, overflow}, {31'b0, ref_ovf(x, y, o)});
    endtask

    // Pick one of the six defined operation codes.
    function automatic logic [3:0] pick_op(input int unsigned k);
        case (k % 6)
            0: return OP_AND;
            1: return OP_OR;
            2: return OP_NOR;
            3: return OP_ADD;
            4: return OP_SUB;
            default: return OP_SLT;
        endcase
    endfunction

    initial begin
        a = '0; b = '0; op = OP_AND;
        #5;
        // Idle state: AND of zeros gives zero result and zero flag.
        check("R10 idle zero", {31'b0, zero}, 32'd1);
        check("R1 idle result", result, '0);

        apply(32'hF0F0_1234, 32'hFF00_FF00, OP_AND);
        apply(32'hF0F0_1234, 32'h0F00_00F0, OP_OR);
        apply(32'hFFFF_0000, 32'h0000_FFFF, OP_NOR);    // R3 NOR yields zero
        apply(32'h0000_0000, 32'h0000_0000, OP_NOR);    // R3 all ones
        apply(32'h7FFF_FFFF, 32'h0000_0001, OP_ADD);    // R8 positive overflow
        apply(32'h8000_0000, 32'h8000_0000, OP_ADD);    // R8 negative overflow, R7 carry, R10 zero
        apply(32'hFFFF_FFFF, 32'h0000_0001, OP_ADD);    // R9 opposite signs, R7 carry, R10 zero
        apply(32'h8000_0000, 32'h7FFF_FFFF, OP_ADD);    // R9 opposite signs
        apply(32'h0000_0005, 32'h0000_0005, OP_SUB);    // R5 zero difference, R7 no borrow
        apply(32'h0000_0003, 32'h0000_0007, OP_SUB);    // R7 borrow
        apply(32'h8000_0000, 32'h0000_0001, OP_SUB);    // R8 overflow
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, OP_SUB);    // R8 overflow
        apply(32'h8000_0000, 32'hFFFF_FFFF, OP_SUB);    // R9 same signs
        apply(32'hFFFF_FFFE, 32'h0000_0001, OP_SLT);    // R6 negative below positive
        apply(32'h0000_0001, 32'hFFFF_FFFE, OP_SLT);    // R6 positive not below
        apply(32'h8000_0000, 32'h7FFF_FFFF, OP_SLT);    // R6 difference overflows
        apply(32'h7FFF_FFFF, 32'h8000_0000, OP_SLT);    // R6 difference overflows
        apply(32'h1234_5678, 32'h1234_5678, OP_SLT);    // R6 equal, R10 zero

        void'($urandom(32'd24681));
        for (int n = 0; n < NRAND; n++) begin
            logic [W-1:0] x, y;
            x = $urandom();
            y = $urandom();
            if (n % 8 == 0) y = x;
            if (n % 8 == 1) y = ~x;
            apply(x, y, pick_op($urandom()));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule